// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Access Controller

This block lets a host read and program single 16-bit words in a small three-wire serial EEPROM with 64 words. The host sees three things: a data register, a control strobe that carries a word address and a direction flag, and a busy flag. For a write, the host first loads the data register. A single control strobe then carries the address and direction and starts the access. The host waits for busy to clear, and after a read it takes the result from the data register.

On the device side the controller drives chip select, a serial clock and serial data out, and it samples serial data in. The serial clock is derived from the system clock by a parameter, so slower or timing-compatible parts can be served. A write always begins with a write-enable command. The write frame follows, and the controller then waits for the device to report that programming is finished. Devices that can only be read work with the read path alone.

Top module: `mwEepromCtrl`

## Requirements
- R1: After reset, busy, chip select, serial clock and serial data out are all 0, and the data register reads 0.
- R2: A control strobe taken while busy is 0 sets busy in the next cycle and latches the address and the direction flag (1 = write, 0 = read).
- R3: A control strobe taken while busy is 1 is ignored. No extra frame is sent and the access in progress keeps its address.
- R4: A data-register load taken while busy is 0 shows on the read-data port from the next cycle. A data-register load taken while busy is 1 is ignored.
- R5: The serial clock runs at the system clock divided by 2*SK_HALF and stays high for exactly SK_HALF cycles. Serial data out changes only while the serial clock is low, and the device samples it on the rising serial-clock edge.
- R6: A read sends start bit 1, opcode 10 and the 6-bit address, all MSB first. It then gives 17 more clocks and samples a dummy 0 followed by data bits 15 down to 0 on the rising edges. The 16 data bits are in the data register when busy clears.
- R7: A write first sends the write-enable frame: start bit 1, opcode 00, address 110000. Chip select then goes low for one bit time. The write frame follows: start bit 1, opcode 01, the address, then the 16 data-register bits, MSB first.
- R8: After the write frame, chip select goes low for one bit time and then high again. The serial clock is held low while serial data in is polled, and busy stays set until the device drives serial data in high.
- R9: At the end of every access, chip select goes low one bit time before busy clears. Chip select and serial clock are low whenever busy is 0.
- R10: A control strobe held high through the cycle in which busy clears is ignored in that cycle. It starts a new access in the first cycle in which busy reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostData | input | DATA_W | Value for a data-register load |
| dataWrEn | input | 1 | Data-register load strobe |
| ctrlWrEn | input | 1 | Control strobe; starts an access when idle |
| ctrlAddr | input | ADDR_W | Word address carried by the control strobe |
| ctrlWrite | input | 1 | Direction carried by the control strobe: 1 write, 0 read |
| busy | output | 1 | Access in progress |
| rdData | output | DATA_W | Data register contents |
| eeCs | output | 1 | Device chip select |
| eeSk | output | 1 | Device serial clock |
| eeDi | output | 1 | Serial data to the device |
| eeDo | input | 1 | Serial data from the device (read data and ready status) |

## Verification
The closest call is between completion and a new start. The sequencer clears busy in one cycle, and a host control strobe asks for a new access. If the strobe lands in the last busy cycle, it must be dropped and not half-taken. The bench holds the control strobe high, with a new read address, across the end of a read. At the negative edge where busy is first seen low, it checks the old read result. It then requires busy to be high again exactly one cycle later. The device model's scoreboard must then see one read frame for the new address, and no extra frame from the strobes that were ignored.

// File: rtl/mwPkg.sv
package mwPkg;

  localparam logic [1:0] OP_EWEN  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  typedef enum logic [3:0] {
    S_IDLE,
    S_EWEN,
    S_GAP1,
    S_WRITE,
    S_GAP2,
    S_POLL,
    S_RDCMD,
    S_RDDATA,
    S_FINISH
  } mwState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic divRun;
    logic skEn;
    logic loadEwen;
    logic loadWrite;
    logic loadRead;
    logic loadRdData;
    logic loadGap;
    logic csSet;
    logic csClr;
    logic captureEn;
    logic captureRd;
    logic dataLoad;
  } mwStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic tick;
    logic fallTick;
    logic bitLast;
    logic doIn;
  } mwStatus_t;

endpackage

// File: rtl/mwDatapath.sv
module mwDatapath
  import mwPkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int SK_HALF = 4,
  parameter bit SYNC_DO = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mwStrobe_t         stb,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] hostData,
  input  logic              eeDo,
  output mwStatus_t         sts,
  output logic [DATA_W-1:0] dataQ,
  output logic              eeCs,
  output logic              eeSk,
  output logic              eeDi
);

  localparam int CMD_W = 3 + ADDR_W;
  localparam int OUT_W = CMD_W + DATA_W;
  localparam int CNT_W = $clog2(OUT_W + 1);
  localparam int DIV_W = $clog2(SK_HALF + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SK_HALF - 1);

  logic [DIV_W-1:0]  divCnt;
  logic              tick;
  logic              skQ;
  logic              csQ;
  logic              riseTick;
  logic              fallTick;
  logic [OUT_W-1:0]  outSh;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] inSh;
  logic              doIn;

  // optional two-stage synchronizer on the device return line
  generate
    if (SYNC_DO) begin : gSync
      logic [1:0] syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[0], eeDo};
      end
      assign doIn = syncQ[1];
    end else begin : gDirect
      assign doIn = eeDo;
    end
  endgenerate

  // serial clock divider
  always_ff @(posedge clk) begin
    if (!rstN)              divCnt <= '0;
    else if (!stb.divRun)   divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                    divCnt <= divCnt + 1'b1;
  end

  assign tick     = stb.divRun && (divCnt == DIV_LAST);
  assign riseTick = tick && stb.skEn && !skQ;
  assign fallTick = tick && stb.skEn && skQ;

  always_ff @(posedge clk) begin
    if (!rstN)          skQ <= 1'b0;
    else if (!stb.skEn) skQ <= 1'b0;
    else if (tick)      skQ <= ~skQ;
  end

  // chip select
  always_ff @(posedge clk) begin
    if (!rstN)          csQ <= 1'b0;
    else if (stb.csSet) csQ <= 1'b1;
    else if (stb.csClr) csQ <= 1'b0;
  end

  // outgoing frame shifter and bit counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSh  <= '0;
      bitCnt <= '0;
    end else if (stb.loadEwen) begin
      outSh  <= {1'b1, OP_EWEN, 2'b11, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
      bitCnt <= CNT_W'(CMD_W - 1);
    end else if (stb.loadRead) begin
      outSh  <= {1'b1, OP_READ, loadAddr, {DATA_W{1'b0}}};
      bitCnt <= CNT_W'(CMD_W - 1);
    end else if (stb.loadWrite) begin
      outSh  <= {1'b1, OP_WRITE, loadAddr, dataQ};
      bitCnt <= CNT_W'(OUT_W - 1);
    end else if (stb.loadRdData) begin
      outSh  <= '0;
      bitCnt <= CNT_W'(DATA_W);
    end else if (stb.loadGap) begin
      outSh  <= '0;
      bitCnt <= '0;
    end else if (fallTick) begin
      outSh  <= {outSh[OUT_W-2:0], 1'b0};
      if (bitCnt != '0) bitCnt <= bitCnt - 1'b1;
    end
  end

  // incoming data shifter: dummy bit drops out of the top after 17 shifts
  always_ff @(posedge clk) begin
    if (!rstN)                        inSh <= '0;
    else if (riseTick && stb.captureEn) inSh <= {inSh[DATA_W-2:0], doIn};
  end

  // host data register
  always_ff @(posedge clk) begin
    if (!rstN)              dataQ <= '0;
    else if (stb.dataLoad)  dataQ <= hostData;
    else if (stb.captureRd) dataQ <= inSh;
  end

  always_comb begin
    sts.tick     = tick;
    sts.fallTick = fallTick;
    sts.bitLast  = (bitCnt == '0);
    sts.doIn     = doIn;
  end

  assign eeCs = csQ;
  assign eeSk = skQ;
  assign eeDi = outSh[OUT_W-1];

  // serial clock high-time monitor
  logic [DIV_W:0] hiCnt;
  always_ff @(posedge clk) begin
    if (!rstN)    hiCnt <= '0;
    else if (skQ) hiCnt <= hiCnt + 1'b1;
    else          hiCnt <= '0;
  end

  assert_sk_high_time_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(skQ) |-> (hiCnt == (DIV_W+1)'(SK_HALF)));

  assert_di_stable_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (skQ && $past(skQ)) |-> $stable(eeDi));

endmodule

// File: rtl/mwControl.sv
module mwControl
  import mwPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [ADDR_W-1:0] ctrlAddr,
  input  logic              ctrlWrite,
  input  logic              dataWrEn,
  input  mwStatus_t         sts,
  output mwStrobe_t         stb,
  output logic [ADDR_W-1:0] loadAddr,
  output logic              busy
);

  mwState_e          state, nxt;
  logic [ADDR_W-1:0] addrQ;
  logic              bitDone;

  assign bitDone  = sts.fallTick && sts.bitLast;
  assign busy     = (state != S_IDLE);
  assign loadAddr = (state == S_IDLE) ? ctrlAddr : addrQ;

  always_comb begin
    stb           = '0;
    nxt           = state;
    stb.divRun    = (state != S_IDLE);
    stb.skEn      = (state != S_IDLE) && (state != S_POLL);
    stb.captureEn = (state == S_RDDATA);
    stb.dataLoad  = dataWrEn && (state == S_IDLE);
    case (state)
      S_IDLE: begin
        if (ctrlWrEn) begin
          stb.csSet = 1'b1;
          if (ctrlWrite) begin
            stb.loadEwen = 1'b1;
            nxt = S_EWEN;
          end else begin
            stb.loadRead = 1'b1;
            nxt = S_RDCMD;
          end
        end
      end
      S_EWEN: if (bitDone) begin
        stb.csClr = 1'b1; stb.loadGap = 1'b1; nxt = S_GAP1;
      end
      S_GAP1: if (bitDone) begin
        stb.csSet = 1'b1; stb.loadWrite = 1'b1; nxt = S_WRITE;
      end
      S_WRITE: if (bitDone) begin
        stb.csClr = 1'b1; stb.loadGap = 1'b1; nxt = S_GAP2;
      end
      S_GAP2: if (bitDone) begin
        stb.csSet = 1'b1; nxt = S_POLL;
      end
      S_POLL: if (sts.tick && sts.doIn) begin
        stb.csClr = 1'b1; stb.loadGap = 1'b1; nxt = S_FINISH;
      end
      S_RDCMD: if (bitDone) begin
        stb.loadRdData = 1'b1; nxt = S_RDDATA;
      end
      S_RDDATA: if (bitDone) begin
        stb.captureRd = 1'b1; stb.csClr = 1'b1; stb.loadGap = 1'b1; nxt = S_FINISH;
      end
      S_FINISH: if (bitDone) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      addrQ <= '0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && ctrlWrEn) addrQ <= ctrlAddr;
    end
  end

  assert_start_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ctrlWrEn));

  assert_busy_strobe_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlWrEn) |=> $stable(addrQ));

endmodule

// File: rtl/mwEepromCtrl.sv
module mwEepromCtrl
  import mwPkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int SK_HALF = 4,
  parameter bit SYNC_DO = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] hostData,
  input  logic              dataWrEn,
  input  logic              ctrlWrEn,
  input  logic [ADDR_W-1:0] ctrlAddr,
  input  logic              ctrlWrite,
  output logic              busy,
  output logic [DATA_W-1:0] rdData,
  output logic              eeCs,
  output logic              eeSk,
  output logic              eeDi,
  input  logic              eeDo
);

  mwStrobe_t         stb;
  mwStatus_t         sts;
  logic [ADDR_W-1:0] loadAddr;

  mwControl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWrEn (ctrlWrEn),
    .ctrlAddr (ctrlAddr),
    .ctrlWrite(ctrlWrite),
    .dataWrEn (dataWrEn),
    .sts      (sts),
    .stb      (stb),
    .loadAddr (loadAddr),
    .busy     (busy)
  );

  mwDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SK_HALF(SK_HALF),
    .SYNC_DO(SYNC_DO)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .loadAddr(loadAddr),
    .hostData(hostData),
    .eeDo    (eeDo),
    .sts     (sts),
    .dataQ   (rdData),
    .eeCs    (eeCs),
    .eeSk    (eeSk),
    .eeDi    (eeDi)
  );

  assert_idle_cs_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !eeCs);

  assert_done_sk_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!eeSk && !eeCs));

endmodule

// File: tb/tb_mwEepromCtrl.sv
module tb_mwEepromCtrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 16;
  localparam int SK_HALF    = 4;
  localparam int PROG_CYC   = 60;
  localparam int WDOG       = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] hostData = '0;
  logic              dataWrEn = 1'b0;
  logic              ctrlWrEn = 1'b0;
  logic [ADDR_W-1:0] ctrlAddr = '0;
  logic              ctrlWrite = 1'b0;
  logic              busy;
  logic [DATA_W-1:0] rdData;
  logic              eeCs, eeSk, eeDi;
  logic              eeDo;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mwEepromCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SK_HALF(SK_HALF)) dut (
    .clk(clk), .rstN(rstN), .hostData(hostData), .dataWrEn(dataWrEn),
    .ctrlWrEn(ctrlWrEn), .ctrlAddr(ctrlAddr), .ctrlWrite(ctrlWrite),
    .busy(busy), .rdData(rdData), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi),
    .eeDo(eeDo)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected frames: {start, op[1:0], addr[5:0], data[15:0]}
  logic [24:0]       expQ[$];
  logic [DATA_W-1:0] shadow[64];

  // ---------------- device model and scoreboard monitor ----------------
  logic [DATA_W-1:0] mem[64];
  logic              pSk, pCs, reading, ewenOn, progPend, progDone;
  int                nBits, progCnt, lastRise;
  logic [24:0]       rx;
  logic [1:0]        curOp;
  logic [5:0]        rdA, pgA;
  logic [15:0]       pgD;

  task automatic compareFrame(input logic [24:0] got, input string tag);
    logic [24:0] e;
    checks++;
    if (expQ.size() == 0) begin
      fails++;
      $display("FAIL R3 unexpected frame actual=%h expected=none", got);
    end else begin
      e = expQ.pop_front();
      if (e != got) begin
        fails++;
        $display("FAIL %s frame actual=%h expected=%h", tag, got, e);
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      pSk = 0; pCs = 0; reading = 0; ewenOn = 0; progPend = 0;
      nBits = 0; progCnt = 0; rx = '0; curOp = '0; lastRise = 0;
      eeDo <= 1'b0;
    end else begin
      if (eeCs && !pCs) begin
        nBits = 0; rx = '0; reading = 0;
        if (progPend) begin
          progPend = 0; progCnt = PROG_CYC; eeDo <= 1'b0;
        end else if (progCnt == 0) eeDo <= 1'b1;
      end
      if (eeSk && !pSk && eeCs) begin
        nBits++;
        if (nBits >= 2)   // R5: one serial clock period per bit
          check((cyc - lastRise) == 2*SK_HALF, "R5 sk period", cyc - lastRise, 2*SK_HALF);
        lastRise = cyc;
        rx = {rx[23:0], eeDi};
        if (nBits == 9) begin
          curOp = rx[7:6];
          if (curOp == 2'b10) begin
            compareFrame({rx[8:0], 16'h0}, "R6");
            reading = 1; rdA = rx[5:0]; eeDo <= 1'b0;
          end else if (curOp == 2'b00) begin
            compareFrame({rx[8:0], 16'h0}, "R7");
            ewenOn = (rx[5:4] == 2'b11);
          end
        end else if (reading && nBits >= 10 && nBits <= 25) begin
          eeDo <= mem[rdA][25 - nBits];
        end else if (nBits == 25 && curOp == 2'b01) begin
          compareFrame(rx, "R7");
          if (ewenOn) begin progPend = 1; pgA = rx[21:16]; pgD = rx[15:0]; end
        end
      end
      if (progCnt > 0) begin
        progCnt--;
        if (progCnt == 0) begin mem[pgA] = pgD; eeDo <= 1'b1; progDone = 1; end
      end
      pCs = eeCs; pSk = eeSk;
    end
    if (cyc == WDOG) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // ---------------- driver ----------------
  task automatic startOp(input logic wr, input logic [5:0] a);
    @(negedge clk);
    while (busy) @(negedge clk);
    ctrlAddr = a; ctrlWrite = wr; ctrlWrEn = 1'b1;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
  endtask

  task automatic waitDone();
    while (busy) @(negedge clk);
    check(eeCs == 1'b0 && eeSk == 1'b0, "R9 pins idle at done", {eeCs, eeSk}, 0);
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [15:0] d, input bit disturb);
    @(negedge clk);
    hostData = d; dataWrEn = 1'b1;
    @(negedge clk);
    dataWrEn = 1'b0;
    check(rdData == d, "R4 data load idle", rdData, d);
    expQ.push_back({1'b1, 2'b00, 6'b110000, 16'h0});
    expQ.push_back({1'b1, 2'b01, a, d});
    shadow[a] = d;
    progDone = 0;
    startOp(1'b1, a);
    if (disturb) begin
      repeat (20) @(negedge clk);
      ctrlAddr = 6'd9; ctrlWrite = 1'b0; ctrlWrEn = 1'b1;
      hostData = 16'hFFFF; dataWrEn = 1'b1;
      @(negedge clk);
      ctrlWrEn = 1'b0; dataWrEn = 1'b0;
    end
    waitDone();
    check(progDone == 1'b1 && progCnt == 0, "R8 busy held until ready", progCnt, 0);
    check(rdData == d, "R4 data held through write", rdData, d);
  endtask

  task automatic doRead(input logic [5:0] a);
    expQ.push_back({1'b1, 2'b10, a, 16'h0});
    startOp(1'b0, a);
    waitDone();
    check(rdData == shadow[a], "R6 read data", rdData, shadow[a]);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i]    = 16'h5A00 ^ (16'(i) * 16'h0101);
      shadow[i] = 16'h5A00 ^ (16'(i) * 16'h0101);
    end
    progDone = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({busy, eeCs, eeSk, eeDi} == 4'b0, "R1 control pins", {busy, eeCs, eeSk, eeDi}, 0);
    check(rdData == '0, "R1 data register", rdData, 0);

    doRead(6'd20);
    doWrite(6'd5, 16'h1234, 1'b1);      // R3/R4 disturbance during write
    doRead(6'd5);
    doWrite(6'd63, 16'hFFFF, 1'b0);
    doWrite(6'd0, 16'h0001, 1'b0);
    doRead(6'd63);
    doRead(6'd0);
    doRead(6'd42);
    doWrite(6'd42, 16'h8000, 1'b0);
    doRead(6'd42);

    // R10: control strobe held across completion of a read
    expQ.push_back({1'b1, 2'b10, 6'd63, 16'h0});
    startOp(1'b0, 6'd63);
    expQ.push_back({1'b1, 2'b10, 6'd1, 16'h0});
    ctrlAddr = 6'd1; ctrlWrite = 1'b0; ctrlWrEn = 1'b1;
    @(negedge clk);
    while (busy) @(negedge clk);
    check(rdData == shadow[63], "R10 first read data", rdData, shadow[63]);
    @(negedge clk);
    ctrlWrEn = 1'b0;
    check(busy == 1'b1, "R10 restart one cycle later", busy, 1);
    waitDone();
    check(rdData == shadow[1], "R10 second read data", rdData, shadow[1]);

    repeat (40) @(negedge clk);
    check(expQ.size() == 0, "R3 all frames seen", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule